// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their signed product of `2*WIDTH` bits. It works one multiplier bit per clock: a one-cycle start request captures both operands and clears the partial-product register. Each following cycle looks at the lowest remaining multiplier bit and the bit that was looked at just before it. From that pair the step adds the multiplicand to the upper half of the accumulator, subtracts it, or leaves the upper half alone. It then shifts the whole accumulator one place to the right and copies the sign bit into the top.

After exactly `WIDTH` steps the unit drops busy and raises done. The product is then held on the output until the next accepted start. A start request that arrives during a multiplication is ignored. The caller keeps start low, or pulses it once, and reads the product while done is high.

Top module: `booth_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A start request while not busy is accepted at that clock edge. In the next cycle `busy_o` is 1 and `done_o` is 0, including when `done_o` was high.
- R3: `busy_o` stays high for exactly `WIDTH` cycles after an accepted start. `done_o` rises in the cycle in which `busy_o` falls, and the two are never high together.
- R4: When `done_o` is high, `product_o` equals the signed product of the two operands captured at the accepted start. This holds for every operand pair, including the most negative value times itself (-8 × -8 = 64 for `WIDTH` = 4).
- R5: `done_o` and `product_o` stay unchanged until the next accepted start.
- R6: A start request while `busy_o` is high has no effect. The operands on the inputs at that time do not alter the product or the completion cycle.
- R7: Each step uses the pair (current multiplier bit, previous bit), where the bit below the least significant multiplier bit is taken as 0. The pair 0,1 adds the multiplicand, 1,0 subtracts it, and 0,0 and 1,1 add nothing. This is followed by an arithmetic right shift. For example 0101 × 1011 gives 8'hE7 (-25).
- R8: The add or subtract is one bit wider than `WIDTH`, so negating the most negative multiplicand yields its true positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when not busy |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | Product valid, held until the next accepted start |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The assertions assume that `start_i`, `mcand_i` and `mplier_i` are known values at every rising edge. They also assume that the operands matter only at the edge where a start is accepted, because the checker captures its expected product at that edge alone. The stimulus changes inputs only on the falling edge and uses single-cycle start pulses, with one exception: a start is deliberately raised during a multiplication, with different operands, to show that it is ignored. The bench also exercises back-to-back starts issued in the same cycle that `done_o` is high.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_SKIP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  input  booth_op_e    op_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] opnd;
  logic         cin;

  always_comb begin
    unique case (op_i)
      OP_ADD:  begin opnd = mcand_i;  cin = 1'b0; end
      OP_SUB:  begin opnd = ~mcand_i; cin = 1'b1; end
      default: begin opnd = '0;       cin = 1'b0; end
    endcase
  end

  assign res_o = acc_i + opnd + W'(cin);
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CW   = $clog2(STEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(STEPS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW   = WIDTH + 1,
  localparam int unsigned PW   = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);
  logic             load, step;
  logic [AW-1:0]    acc_q, mcand_q, sum;
  logic [WIDTH-1:0] mplr_q;
  logic             prev_q;
  booth_op_e        op;

  booth_seq_ctrl #(.STEPS(WIDTH)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_recode recode_i (
    .cur_i (mplr_q[0]),
    .prev_i(prev_q),
    .op_o  (op)
  );

  // one bit wider than WIDTH so -(-2^(WIDTH-1)) is representable
  booth_addsub #(.W(AW)) addsub_i (
    .acc_i  (acc_q),
    .mcand_i(mcand_q),
    .op_i   (op),
    .res_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      prev_q  <= 1'b0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= {mcand_i[WIDTH-1], mcand_i};
      mplr_q  <= mplier_i;
      prev_q  <= 1'b0;
    end else if (step) begin
      // arithmetic right shift of {acc, mplr, prev}
      acc_q  <= {sum[AW-1], sum[AW-1:1]};
      mplr_q <= {sum[0], mplr_q[WIDTH-1:1]};
      prev_q <= mplr_q[0];
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mplr_q};
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned PW   = 2 * WIDTH,
  localparam int unsigned CW   = $clog2(WIDTH + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [PW-1:0]    product_o
);
  logic signed [PW-1:0] exp_q;
  logic [CW-1:0]        bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (start_i && !busy_o) exp_q <= $signed(mcand_i) * $signed(mplier_i);
      bcnt_q <= busy_o ? bcnt_q + 1'b1 : '0;
    end
  end

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  a_r3_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r3_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt_q < CW'(WIDTH)));

  a_r3_done_at_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (bcnt_q == CW'(WIDTH)));

  a_r4_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (product_o == exp_q));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(product_o)));

  a_r6_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && bcnt_q != CW'(WIDTH - 1)) |=> busy_o);
endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .product_o(product_o)
);

// File: tb/booth_mult_tb.sv
module booth_mult_tb_top;
  localparam int N  = 4;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  mcand = '0, mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit              m_busy = 0, m_done = 0;
  int              m_cnt = 0;
  logic [PW-1:0]   m_prod = '0;

  always #2 clk = ~clk;

  booth_mult #(.WIDTH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
    end else if (start && !m_busy) begin
      m_busy = 1; m_done = 0; m_cnt = 0;
      m_prod = PW'($signed(mcand) * $signed(mplier));
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == N) begin m_busy = 0; m_done = 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle on the falling edge, before inputs change
  task automatic cyc();
    @(negedge clk);
    chk(busy == m_busy, "R2/R3 busy", busy, m_busy);
    chk(done == m_done, "R3/R5 done", done, m_done);
    if (m_done) chk(product == m_prod, "R4/R5 product", product, m_prod);
  endtask

  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input int idle);
    mcand = a; mplier = b; start = 1'b1;
    cyc();
    start = 1'b0;
    repeat (N + idle) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && product == '0, "R1 reset", product, 0);
    rst_n = 1'b1;
    cyc();
    chk(product == '0, "R1 after reset", product, 0);

    // R7 directed: 0101 x 1011 = -25
    run(4'b0101, 4'b1011, 1);
    chk(product == 8'hE7, "R7 booth 5*-5", product, 8'hE7);

    // R8 most negative squared
    run(4'b1000, 4'b1000, 1);
    chk(product == 8'h40, "R8 -8*-8", product, 8'h40);
    run(4'b1000, 4'b0111, 1);
    chk(product == 8'hC8, "R8 -8*7", product, 8'hC8);

    // R4 exhaustive
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run(N'(i), N'(j), (i + j) % 3);

    // R6 start while busy with other operands
    mcand = 4'd3; mplier = 4'd5; start = 1'b1;
    cyc();
    mcand = 4'd7; mplier = 4'd7;
    cyc();
    cyc();
    start = 1'b0;
    repeat (N) cyc();
    chk(product == 8'd15, "R6 ignored start", product, 15);

    // R2 restart exactly while done is high
    run(4'd2, 4'hF, 0);
    run(4'hF, 4'hF, 2);
    chk(product == 8'd1, "R2 back-to-back", product, 1);

    // R5 hold
    repeat (5) cyc();
    chk(done == 1 && product == 8'd1, "R5 hold", product, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule